// File: doc/BRIEF.md
# Dual-Clock Memory-Mapped Serial Port

This block is a byte-wide serial port that sits on an 8-bit processor bus. It takes up the two top addresses of a 256-byte address space. The bus side runs on the system clock, which may be slow. The serial transmitter, the receiver and the bit-rate counters run on their own serial clock, nominally 12 MHz. The line format is one start bit, eight data bits sent least significant bit first, no parity and one stop bit. Each bit lasts `CLKS_PER_BIT` serial-clock cycles, and the default of 1250 gives 9600 baud.

Address 0xFE is the data register. A write to it hands one byte to the transmitter. A read from it returns the byte held in the receive buffer. Address 0xFF is the status register when read. A write of any value to it is a clear command. There is no queue in either direction:

- The transmit path holds one byte. Its only form of back-pressure is the busy flag, and software must poll that flag before it writes.
- The receive path holds one byte and must be re-armed by a clear before every byte.

Frames that arrive while the receiver is not armed are lost. The bus interface is plain register access with no valid/ready pair.

Status bits are packed as bit 0 = transmitter busy and bit 1 = receive buffer full. Bits 7:2 read as zero. The same two flags are also brought out as pins.

Top module: `uart_mmio`

## Requirements
- R1: After reset, `serial_out` is 1, `tx_busy` and `rx_full` are 0, and a read of 0xFF returns 0x00.
- R2: A write to 0xFE while the transmitter is idle produces one frame on `serial_out`. The frame is a low start bit, the eight data bits with bit 0 first, and a high stop bit, each `CLKS_PER_BIT` serial-clock cycles long.
- R3: `tx_busy` (status bit 0) is 1 from the system cycle after an accepted write to 0xFE until the stop bit has been sent. `serial_out` is 1 whenever `tx_busy` is 0.
- R4: A write to 0xFE while `tx_busy` is 1 is ignored. No extra frame is sent, and the byte being sent is unchanged.
- R5: After reset the receiver is not armed. Incoming frames are dropped and `rx_full` stays 0.
- R6: A write of any value to 0xFF sets `rx_full` to 0 in the next system cycle and arms the receiver for exactly one byte.
- R7: When the receiver is armed and a frame with a high stop bit arrives, sampled at mid-bit, `rx_full` (status bit 1) becomes 1 and a read of 0xFE returns the byte.
- R8: While `rx_full` is 1, further frames are discarded and the value read from 0xFE does not change.
- R9: A frame whose stop bit is sampled low is discarded. The receiver stays armed and waits for the line to return high before it looks for the next start bit.
- R10: Reads of any address other than 0xFE and 0xFF return 0x00. Status bits 7:2 read as 0.
- R11: Reading 0xFE has no side effect: `rx_full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (bus) clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| ser_clk | input | 1 | Serial clock (nominally 12 MHz) |
| ser_rst_n | input | 1 | Active-low asynchronous reset, serial domain |
| bus_addr | input | 8 | Bus address |
| bus_we | input | 1 | Write strobe, one system cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tx_busy | output | 1 | Transmitter busy (same as status bit 0) |
| rx_full | output | 1 | Receive buffer holds a byte (same as status bit 1) |
| serial_in | input | 1 | Serial receive line, idle high |
| serial_out | output | 1 | Serial transmit line, idle high |

## Verification
The checks assume the following about the inputs:
- Both resets are asserted together and released together.
- The incoming serial line keeps to whole bit times measured on the serial clock.
- Software never issues a clear at the moment a received frame is completing. If it did, a byte stored under the old arming could be reported after the new clear and then be overwritten.

The stimulus drives each serial bit for exactly `CLKS_PER_BIT` serial-clock periods. It issues clears only while the line is idle between frames. It starts transmit writes only after polling the busy flag, except for the deliberate write into a busy transmitter.

// File: rtl/uart_mmio_pkg.sv
`timescale 1ns/1ps
package uart_mmio_pkg;
  localparam logic [7:0] ADDR_DATA = 8'hFE;
  localparam logic [7:0] ADDR_CTRL = 8'hFF;
  localparam int STAT_BUSY = 0;
  localparam int STAT_FULL = 1;
  localparam int BYTE_W    = 8;

  typedef enum logic [1:0] {
    TXS_IDLE,
    TXS_START,
    TXS_DATA,
    TXS_STOP
  } tx_state_t;

  typedef enum logic [2:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_STOP,
    RXS_BREAK
  } rx_state_t;
endpackage

// File: rtl/cdc_sync2.sv
`timescale 1ns/1ps
module cdc_sync2 #(
  parameter int   WIDTH     = 1,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {WIDTH{RESET_VAL}};
      q    <= {WIDTH{RESET_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cdc_pulse.sv
`timescale 1ns/1ps
// Single-cycle event crossing: the source flips a toggle, the destination
// synchronises the toggle and emits a pulse on every change.
module cdc_pulse (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic src_tgl;
  logic dst_tgl;
  logic dst_prev;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)     src_tgl <= 1'b0;
    else if (src_pulse) src_tgl <= ~src_tgl;
  end

  cdc_sync2 #(.WIDTH(1), .RESET_VAL(1'b0)) u_sync (
    .clk  (dst_clk),
    .rst_n(dst_rst_n),
    .d    (src_tgl),
    .q    (dst_tgl)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) dst_prev <= 1'b0;
    else            dst_prev <= dst_tgl;
  end

  assign dst_pulse = dst_tgl ^ dst_prev;
endmodule

// File: rtl/uart_tx_engine.sv
`timescale 1ns/1ps
module uart_tx_engine
  import uart_mmio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1250,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] din,
  output logic                 line,
  output logic                 done
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] LAST_BIT  = IW'(DATA_BITS - 1);

  tx_state_t            state;
  logic [CW-1:0]        tick;
  logic [IW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 bit_end;

  assign bit_end = (tick == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TXS_IDLE;
      tick    <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      line    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        TXS_IDLE: begin
          line <= 1'b1;
          tick <= '0;
          if (start) begin
            shreg <= din;
            line  <= 1'b0;
            state <= TXS_START;
          end
        end
        TXS_START: begin
          if (bit_end) begin
            tick    <= '0;
            bit_idx <= '0;
            line    <= shreg[0];
            shreg   <= {1'b0, shreg[DATA_BITS-1:1]};
            state   <= TXS_DATA;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        TXS_DATA: begin
          if (bit_end) begin
            tick <= '0;
            if (bit_idx == LAST_BIT) begin
              line  <= 1'b1;
              state <= TXS_STOP;
            end else begin
              line    <= shreg[0];
              shreg   <= {1'b0, shreg[DATA_BITS-1:1]};
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        TXS_STOP: begin
          if (bit_end) begin
            tick  <= '0;
            done  <= 1'b1;
            state <= TXS_IDLE;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= TXS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
`timescale 1ns/1ps
module uart_rx_engine
  import uart_mmio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1250,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  output logic [DATA_BITS-1:0] data,
  output logic                 valid
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_TICK = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [IW-1:0] LAST_BIT  = IW'(DATA_BITS - 1);

  rx_state_t     state;
  logic [CW-1:0] tick;
  logic [IW-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RXS_IDLE;
      tick    <= '0;
      bit_idx <= '0;
      data    <= '0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state)
        RXS_IDLE: begin
          tick <= '0;
          if (!line) state <= RXS_START;
        end
        RXS_START: begin
          if (tick == HALF_TICK) begin
            tick    <= '0;
            bit_idx <= '0;
            state   <= line ? RXS_IDLE : RXS_DATA;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RXS_DATA: begin
          if (tick == LAST_TICK) begin
            tick <= '0;
            data <= {line, data[DATA_BITS-1:1]};
            if (bit_idx == LAST_BIT) state <= RXS_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RXS_STOP: begin
          if (tick == LAST_TICK) begin
            tick <= '0;
            if (line) begin
              valid <= 1'b1;
              state <= RXS_IDLE;
            end else begin
              state <= RXS_BREAK;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RXS_BREAK: begin
          if (line) state <= RXS_IDLE;
        end
        default: state <= RXS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio.sv
`timescale 1ns/1ps
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1250
) (
  input  logic       sys_clk,
  input  logic       sys_rst_n,
  input  logic       ser_clk,
  input  logic       ser_rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tx_busy,
  output logic       rx_full,
  input  logic       serial_in,
  output logic       serial_out
);
  // ---------------- system domain ----------------
  logic              wr_data, wr_ctrl, tx_accept;
  logic [BYTE_W-1:0] tx_hold;
  logic              tx_busy_q, rx_full_q;
  logic              tx_done_sys, rx_fill_sys;

  assign wr_data   = bus_we && (bus_addr == ADDR_DATA);
  assign wr_ctrl   = bus_we && (bus_addr == ADDR_CTRL);
  assign tx_accept = wr_data && !tx_busy_q;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      tx_hold   <= '0;
      tx_busy_q <= 1'b0;
    end else if (tx_accept) begin
      tx_hold   <= bus_wdata;
      tx_busy_q <= 1'b1;
    end else if (tx_done_sys) begin
      tx_busy_q <= 1'b0;
    end
  end

  // A clear wins over a fill arriving in the same cycle.
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)       rx_full_q <= 1'b0;
    else if (wr_ctrl)     rx_full_q <= 1'b0;
    else if (rx_fill_sys) rx_full_q <= 1'b1;
  end

  // ---------------- serial domain ----------------
  logic              tx_start_ser, tx_done_ser;
  logic              clr_ser, rx_line;
  logic [BYTE_W-1:0] rx_word, rx_buf;
  logic              rx_valid, rx_armed, rx_store;

  assign rx_store = rx_valid && rx_armed;

  always_ff @(posedge ser_clk or negedge ser_rst_n) begin
    if (!ser_rst_n) begin
      rx_armed <= 1'b0;
      rx_buf   <= '0;
    end else begin
      if (rx_store) begin
        rx_buf   <= rx_word;
        rx_armed <= 1'b0;
      end
      if (clr_ser) rx_armed <= 1'b1;
    end
  end

  cdc_sync2 #(.WIDTH(1), .RESET_VAL(1'b1)) u_rx_sync (
    .clk(ser_clk), .rst_n(ser_rst_n), .d(serial_in), .q(rx_line)
  );

  cdc_pulse u_start_xfer (
    .src_clk(sys_clk), .src_rst_n(sys_rst_n), .src_pulse(tx_accept),
    .dst_clk(ser_clk), .dst_rst_n(ser_rst_n), .dst_pulse(tx_start_ser)
  );
  cdc_pulse u_done_xfer (
    .src_clk(ser_clk), .src_rst_n(ser_rst_n), .src_pulse(tx_done_ser),
    .dst_clk(sys_clk), .dst_rst_n(sys_rst_n), .dst_pulse(tx_done_sys)
  );
  cdc_pulse u_clr_xfer (
    .src_clk(sys_clk), .src_rst_n(sys_rst_n), .src_pulse(wr_ctrl),
    .dst_clk(ser_clk), .dst_rst_n(ser_rst_n), .dst_pulse(clr_ser)
  );
  cdc_pulse u_fill_xfer (
    .src_clk(ser_clk), .src_rst_n(ser_rst_n), .src_pulse(rx_store),
    .dst_clk(sys_clk), .dst_rst_n(sys_rst_n), .dst_pulse(rx_fill_sys)
  );

  uart_tx_engine #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(BYTE_W)) u_tx (
    .clk(ser_clk), .rst_n(ser_rst_n), .start(tx_start_ser),
    .din(tx_hold), .line(serial_out), .done(tx_done_ser)
  );

  uart_rx_engine #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(BYTE_W)) u_rx (
    .clk(ser_clk), .rst_n(ser_rst_n), .line(rx_line),
    .data(rx_word), .valid(rx_valid)
  );

  // ---------------- bus read ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_DATA) begin
      bus_rdata = rx_buf;
    end else if (bus_addr == ADDR_CTRL) begin
      bus_rdata[STAT_BUSY] = tx_busy_q;
      bus_rdata[STAT_FULL] = rx_full_q;
    end
  end

  assign tx_busy = tx_busy_q;
  assign rx_full = rx_full_q;
endmodule

// File: rtl/uart_mmio_checker.sv
`timescale 1ns/1ps
module uart_mmio_checker (
  input logic       sys_clk,
  input logic       sys_rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_we,
  input logic       tx_busy,
  input logic       rx_full,
  input logic       serial_out,
  input logic [7:0] tx_hold,
  input logic [7:0] rx_buf
);
  a_r3_busy_after_write: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr == 8'hFE && !tx_busy) |=> tx_busy);

  a_r3_line_idle: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !tx_busy |-> serial_out);

  a_r4_hold_stable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(tx_hold));

  a_r6_clear: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr == 8'hFF) |=> !rx_full);

  a_r8_buffer_frozen: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (rx_full && $past(rx_full)) |-> $stable(rx_buf));
endmodule

bind uart_mmio uart_mmio_checker u_uart_mmio_checker (
  .sys_clk   (sys_clk),
  .sys_rst_n (sys_rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .tx_busy   (tx_busy),
  .rx_full   (rx_full),
  .serial_out(serial_out),
  .tx_hold   (tx_hold),
  .rx_buf    (rx_buf)
);

// File: tb/test_uart_mmio.sv
`timescale 1ns/1ps
module test_uart_mmio;
  localparam int CPB     = 16;
  localparam int SER_PER = 84;
  localparam int BIT_NS  = CPB * SER_PER;

  logic       sys_clk = 1'b0;
  logic       ser_clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       ser_rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_busy, rx_full;
  logic       serial_in = 1'b1;
  logic       serial_out;

  always #2.5 sys_clk = ~sys_clk;
  always #42  ser_clk = ~ser_clk;

  uart_mmio #(.CLKS_PER_BIT(CPB)) i_uart_mmio (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_busy(tx_busy), .rx_full(rx_full), .serial_in(serial_in), .serial_out(serial_out)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit run_checks = 1'b0;

  // Reference model state
  bit         model_armed   = 1'b0;
  bit         model_pending = 1'b0;
  logic [7:0] model_byte    = 8'h00;
  bit         mon_active    = 1'b0;
  logic [7:0] tx_seen[$];

  task automatic check_eq(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(posedge sys_clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge sys_clk); #1;
    bus_we = 1'b0; bus_addr = 8'h00;
    if (a == 8'hFF) begin
      model_armed   = 1'b1;
      model_pending = 1'b0;
    end
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(posedge sys_clk); #1;
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic send_frame(logic [7:0] b, bit stop_ok);
    if (model_armed && stop_ok) begin
      model_pending = 1'b1;
      model_byte    = b;
      model_armed   = 1'b0;
    end
    serial_in = 1'b0;
    #(BIT_NS);
    for (int i = 0; i < 8; i++) begin
      serial_in = b[i];
      #(BIT_NS);
    end
    serial_in = stop_ok;
    #(BIT_NS);
    serial_in = 1'b1;
    #(2 * BIT_NS);
  endtask

  task automatic wait_tx_idle();
    for (int i = 0; i < 20000 && tx_busy; i++) @(posedge sys_clk);
    #1;
  endtask

  // Independent decoder of the transmit line
  initial begin
    logic [7:0] b;
    wait (run_checks);
    forever begin
      @(negedge serial_out);
      mon_active = 1'b1;
      #(BIT_NS / 2);
      check_eq("R2 start bit", serial_out, 0);
      for (int i = 0; i < 8; i++) begin
        #(BIT_NS);
        b[i] = serial_out;
      end
      #(BIT_NS);
      check_eq("R2 stop bit", serial_out, 1);
      tx_seen.push_back(b);
      mon_active = 1'b0;
    end
  end

  // Per-clock comparison with the model
  always @(negedge sys_clk) begin
    if (run_checks) begin
      n_tests++;
      if (mon_active && !tx_busy) begin
        n_fail++;
        $display("FAIL R3 tx_busy actual=0 expected=1 during frame");
      end
      n_tests++;
      if (rx_full && !model_pending) begin
        n_fail++;
        $display("FAIL R5 rx_full actual=1 expected=0 (no byte accepted)");
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge sys_clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    #200;
    sys_rst_n = 1'b1;
    ser_rst_n = 1'b1;
    repeat (10) @(posedge sys_clk);
    #1;
    run_checks = 1'b1;

    // R1 reset state
    check_eq("R1 serial_out", serial_out, 1);
    check_eq("R1 tx_busy", tx_busy, 0);
    check_eq("R1 rx_full", rx_full, 0);
    bus_read(8'hFF, rd); check_eq("R1 status", rd, 8'h00);

    // R10 unmapped reads
    bus_read(8'h00, rd); check_eq("R10 addr 00", rd, 8'h00);
    bus_read(8'h80, rd); check_eq("R10 addr 80", rd, 8'h00);
    bus_read(8'hFD, rd); check_eq("R10 addr FD", rd, 8'h00);

    // R2/R3/R4 transmit
    bus_write(8'hFE, 8'hA5);
    check_eq("R3 busy after write", tx_busy, 1);
    bus_read(8'hFF, rd); check_eq("R3 status bit0", rd, 8'h01);
    bus_write(8'hFE, 8'h3C);
    wait_tx_idle();
    #(12 * BIT_NS);
    check_eq("R4 one frame only", tx_seen.size(), 1);
    if (tx_seen.size() > 0) check_eq("R2 byte A5", tx_seen.pop_front(), 8'hA5);
    check_eq("R3 idle line", serial_out, 1);
    check_eq("R3 busy cleared", tx_busy, 0);

    bus_write(8'hFE, 8'h00);
    wait_tx_idle();
    bus_write(8'hFE, 8'hFF);
    wait_tx_idle();
    bus_write(8'hFE, 8'h81);
    wait_tx_idle();
    #(BIT_NS);
    check_eq("R2 frame count", tx_seen.size(), 3);
    if (tx_seen.size() == 3) begin
      check_eq("R2 byte 00", tx_seen.pop_front(), 8'h00);
      check_eq("R2 byte FF", tx_seen.pop_front(), 8'hFF);
      check_eq("R2 byte 81", tx_seen.pop_front(), 8'h81);
    end

    // R5 not armed after reset
    send_frame(8'h55, 1'b1);
    check_eq("R5 unarmed drop", rx_full, 0);

    // R6/R7 arm and receive
    bus_write(8'hFF, 8'h00);
    check_eq("R6 cleared", rx_full, 0);
    send_frame(8'h96, 1'b1);
    check_eq("R7 full", rx_full, 1);
    bus_read(8'hFE, rd); check_eq("R7 data", rd, 8'h96);
    bus_read(8'hFF, rd); check_eq("R7 status bit1", rd, 8'h02);
    bus_read(8'hFE, rd);
    check_eq("R11 read keeps full", rx_full, 1);

    // R8 discard while full
    send_frame(8'h11, 1'b1);
    bus_read(8'hFE, rd); check_eq("R8 data kept", rd, 8'h96);
    check_eq("R8 still full", rx_full, 1);

    // R9 framing error keeps receiver armed
    bus_write(8'hFF, 8'h5A);
    check_eq("R6 clear any value", rx_full, 0);
    send_frame(8'h0F, 1'b0);
    check_eq("R9 bad stop dropped", rx_full, 0);
    send_frame(8'hC3, 1'b1);
    check_eq("R9 still armed", rx_full, 1);
    bus_read(8'hFE, rd); check_eq("R9 next byte", rd, 8'hC3);

    // Concurrent transmit and receive
    bus_write(8'hFF, 8'h00);
    fork
      send_frame(8'h3C, 1'b1);
      bus_write(8'hFE, 8'h5E);
    join
    wait_tx_idle();
    #(BIT_NS);
    check_eq("R7 concurrent full", rx_full, 1);
    bus_read(8'hFE, rd); check_eq("R7 concurrent data", rd, model_byte);
    check_eq("R2 concurrent count", tx_seen.size(), 1);
    if (tx_seen.size() == 1) check_eq("R2 concurrent byte", tx_seen.pop_front(), 8'h5E);

    run_checks = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule